// File: doc/BRIEF.md
# Peripheral Interrupt Pending and Vector Controller

This block gathers interrupt events from the on-chip peripherals of a small microcontroller. These are serial transmit and receive, two timer overflows, a timer capture, an external edge pin, A/D completion, output events, software timer events and input FIFO conditions. Each event is latched into a pending bit. The pending bits are qualified by a per-source mask and a global enable. The block presents to the CPU an interrupt request and the 16-bit vector address of the winning source. When the CPU acknowledges, the pending bit of the vectored source is cleared.

Some events feed more than one pending bit. A serial transmit or receive event sets its dedicated bit and also a shared serial bit. A timer 2 overflow sets its dedicated bit and, when enabled, also the shared timer overflow bit. Software masks the path it does not use. Timer 2 overflow is detected inside the block from the timer 2 count value, at 0000H or at 8000H. A status register records which timer overflowed.

A small register bus gives access to the mask, the pending bits, the control bits and the overflow status.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask, pending, control and status registers read as zero, `irq` is low and `vecOut` is 0000H.
- R2: A one-cycle strobe sets the pending bit of its slot at the next clock edge. The slots are: A/D done 1, data available 2, output event 3, software timer 5, FIFO four entries 9, FIFO full 12. Pending bit n appears at bit n of register 1.
- R3: A transmit strobe sets slots 7 and 6. A receive strobe sets slots 8 and 6.
- R4: Slot 0 (shared timer overflow) is set by a timer 1 overflow only when control bit 2 is 1. It is set by a timer 2 overflow only when control bit 3 is 1. A timer 2 overflow always sets slot 11.
- R5: A timer 2 overflow is detected on the cycle in which `t2Count` changes to the target value. The target is 0000H when control bit 7 is 0 and 8000H when it is 1. A count that stays at the target raises no further event.
- R6: Status bit 5 is set by a timer 1 overflow and status bit 4 by a timer 2 overflow, whatever the enables. Reading register 3 clears both bits. An overflow in the same cycle as the read sets its bit again.
- R7: A rising edge on `extPin` sets slot 4, and a rising edge on `capPin` sets slot 10. Each pin passes through one sampling register and one edge register, so the pending bit appears at the second clock edge after the pin rises. A level held high raises only one event.
- R8: `irq` is high when control bit 0 is 1 and some pending bit is set with its mask bit. `vecOut` gives the address of the highest-numbered such slot, or 0000H when there is none. Masked slots are ignored. The slot addresses 0 to 12 are 2000H, 2002H, 2004H, 2006H, 2008H, 200AH, 200CH, 2030H, 2032H, 2034H, 2036H, 2038H and 203CH.
- R9: An `ackIn` pulse clears the pending bit of the slot then shown on `vecOut`, at that clock edge, and no other bit. An event for that slot in the same cycle keeps the bit set.
- R10: The bus has four registers. Register 0 is the mask, bits 12:0, read and write. Register 1 is pending: reads return the bits, and writing a 1 clears that bit. Register 2 is control, with bits 0, 2, 3 and 7 stored and read back and all other bits reading 0. Register 3 is the read-only status. `rData` shows the register selected by `addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEvt | input | 1 | Serial transmit event strobe |
| rxEvt | input | 1 | Serial receive event strobe |
| t1Ovf | input | 1 | Timer 1 overflow strobe |
| adDone | input | 1 | A/D conversion complete strobe |
| dataAvail | input | 1 | Input data available strobe |
| outEvt | input | 1 | Output pin event strobe |
| swTimer | input | 1 | Software timer event strobe |
| fifoFour | input | 1 | Input FIFO reached four entries |
| fifoFull | input | 1 | Input FIFO full |
| extPin | input | 1 | External interrupt pin |
| capPin | input | 1 | Timer 2 capture pin |
| t2Count | input | 16 | Timer 2 count value |
| addr | input | 2 | Register select |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| wData | input | 16 | Write data |
| rData | output | 16 | Read data of the selected register |
| ackIn | input | 1 | CPU acknowledge of the shown vector |
| irq | output | 1 | Interrupt request |
| vecOut | output | 16 | Vector address of the winning source |

## Verification
A pending bit that is set wrongly or lost shows at once in `irq` and `vecOut`, in the cycle after the event or the acknowledge. It also shows in register 1 whenever that register is selected. A slip in the priority scan or in the vector table shows as a wrong `vecOut` as soon as two enabled sources are pending together. A wrong pin synchronizer or timer 2 target shows as a missing or extra pending bit two cycles after the pin edge, or one cycle after the count step. A status bit that fails to clear shows in the next read of register 3.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int NSRC = 13;
  localparam int IDX_W = 4;

  localparam int SLOT_TOVF = 0;
  localparam int SLOT_AD = 1;
  localparam int SLOT_AVAIL = 2;
  localparam int SLOT_OUTEV = 3;
  localparam int SLOT_EXT = 4;
  localparam int SLOT_SWT = 5;
  localparam int SLOT_SER = 6;
  localparam int SLOT_TX = 7;
  localparam int SLOT_RX = 8;
  localparam int SLOT_FIFO4 = 9;
  localparam int SLOT_CAP = 10;
  localparam int SLOT_T2OVF = 11;
  localparam int SLOT_FULL = 12;

  localparam logic [1:0] REG_MASK = 2'd0;
  localparam logic [1:0] REG_PEND = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  typedef struct packed {
    logic [NSRC-1:0] clrBits;
    logic statClr;
  } ctlStrobe_t;

  function automatic logic [15:0] slotVector(input logic [IDX_W-1:0] idx);
    if (idx < 4'd7) return 16'h2000 + 16'(idx) * 16'd2;
    else if (idx < 4'd12) return 16'h2030 + 16'(idx - 4'd7) * 16'd2;
    else if (idx == 4'd12) return 16'h203C;
    else return 16'h0000;
  endfunction
endpackage

// File: rtl/irq_vector_core.sv
module irq_vector_core
  import irq_vector_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic txEvt,
  input  logic rxEvt,
  input  logic t1Ovf,
  input  logic adDone,
  input  logic dataAvail,
  input  logic outEvt,
  input  logic swTimer,
  input  logic fifoFour,
  input  logic fifoFull,
  input  logic extPin,
  input  logic capPin,
  input  logic [CNT_W-1:0] t2Count,
  input  logic t1En,
  input  logic t2En,
  input  logic t2Sel,
  input  ctlStrobe_t strb,
  input  logic [NSRC-1:0] maskBits,
  output logic [NSRC-1:0] pend,
  output logic [1:0] stat,
  output logic [NSRC-1:0] setBits,
  output logic [IDX_W-1:0] winIdx,
  output logic winValid
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pinIn, pinSync, pinPrev, pinEdge;
  logic [CNT_W-1:0] t2Prev, t2Target;
  logic t2OvfDet;
  logic [NSRC-1:0] active;

  assign pinIn = {capPin, extPin};

  for (genvar p = 0; p < NPIN; p++) begin : gPin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinSync[p] <= 1'b0;
        pinPrev[p] <= 1'b0;
      end else begin
        pinSync[p] <= pinIn[p];
        pinPrev[p] <= pinSync[p];
      end
    end
    assign pinEdge[p] = pinSync[p] & ~pinPrev[p];
  end

  assign t2Target = t2Sel ? HALF : '0;
  assign t2OvfDet = (t2Count == t2Target) && (t2Prev != t2Count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) t2Prev <= '0;
    else t2Prev <= t2Count;
  end

  always_comb begin
    setBits = '0;
    setBits[SLOT_TOVF] = (t1Ovf & t1En) | (t2OvfDet & t2En);
    setBits[SLOT_AD] = adDone;
    setBits[SLOT_AVAIL] = dataAvail;
    setBits[SLOT_OUTEV] = outEvt;
    setBits[SLOT_EXT] = pinEdge[0];
    setBits[SLOT_SWT] = swTimer;
    setBits[SLOT_SER] = txEvt | rxEvt;
    setBits[SLOT_TX] = txEvt;
    setBits[SLOT_RX] = rxEvt;
    setBits[SLOT_FIFO4] = fifoFour;
    setBits[SLOT_CAP] = pinEdge[1];
    setBits[SLOT_T2OVF] = t2OvfDet;
    setBits[SLOT_FULL] = fifoFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= '0;
    else pend <= (pend & ~strb.clrBits) | setBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stat <= '0;
    else begin
      stat[0] <= (stat[0] & ~strb.statClr) | t2OvfDet;
      stat[1] <= (stat[1] & ~strb.statClr) | t1Ovf;
    end
  end

  assign active = pend & maskBits;

  always_comb begin
    winValid = 1'b0;
    winIdx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i]) begin
        winValid = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_regs.sv
module irq_vector_regs
  import irq_vector_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  input  logic ackIn,
  input  logic [IDX_W-1:0] winIdx,
  input  logic winValid,
  input  logic [NSRC-1:0] pend,
  input  logic [1:0] stat,
  output logic [NSRC-1:0] maskReg,
  output logic gEn,
  output logic t1En,
  output logic t2En,
  output logic t2Sel,
  output ctlStrobe_t strb
);
  logic [NSRC-1:0] ackBits, w1cBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      gEn <= 1'b0;
      t1En <= 1'b0;
      t2En <= 1'b0;
      t2Sel <= 1'b0;
    end else if (wrEn) begin
      if (addr == REG_MASK) maskReg <= wData[NSRC-1:0];
      if (addr == REG_CTRL) begin
        gEn <= wData[0];
        t1En <= wData[2];
        t2En <= wData[3];
        t2Sel <= wData[7];
      end
    end
  end

  always_comb begin
    ackBits = '0;
    if (ackIn && winValid) ackBits[winIdx] = 1'b1;
  end

  assign w1cBits = (wrEn && addr == REG_PEND) ? wData[NSRC-1:0] : '0;
  assign strb.clrBits = ackBits | w1cBits;
  assign strb.statClr = rdEn && (addr == REG_STAT);

  always_comb begin
    rData = '0;
    case (addr)
      REG_MASK: rData[NSRC-1:0] = maskReg;
      REG_PEND: rData[NSRC-1:0] = pend;
      REG_CTRL: begin
        rData[0] = gEn;
        rData[2] = t1En;
        rData[3] = t2En;
        rData[7] = t2Sel;
      end
      default: begin
        rData[4] = stat[0];
        rData[5] = stat[1];
      end
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic txEvt,
  input  logic rxEvt,
  input  logic t1Ovf,
  input  logic adDone,
  input  logic dataAvail,
  input  logic outEvt,
  input  logic swTimer,
  input  logic fifoFour,
  input  logic fifoFull,
  input  logic extPin,
  input  logic capPin,
  input  logic [CNT_W-1:0] t2Count,
  input  logic [ADDR_W-1:0] addr,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  input  logic ackIn,
  output logic irq,
  output logic [15:0] vecOut
);
  ctlStrobe_t strb;
  logic [NSRC-1:0] pend, maskReg, setBits;
  logic [1:0] stat;
  logic [IDX_W-1:0] winIdx;
  logic winValid, gEn, t1En, t2En, t2Sel;

  irq_vector_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wData(wData), .rData(rData), .ackIn(ackIn), .winIdx(winIdx),
    .winValid(winValid), .pend(pend), .stat(stat), .maskReg(maskReg),
    .gEn(gEn), .t1En(t1En), .t2En(t2En), .t2Sel(t2Sel), .strb(strb)
  );

  irq_vector_core #(.CNT_W(CNT_W)) uCore (
    .clk(clk), .rstN(rstN), .txEvt(txEvt), .rxEvt(rxEvt), .t1Ovf(t1Ovf),
    .adDone(adDone), .dataAvail(dataAvail), .outEvt(outEvt),
    .swTimer(swTimer), .fifoFour(fifoFour), .fifoFull(fifoFull),
    .extPin(extPin), .capPin(capPin), .t2Count(t2Count), .t1En(t1En),
    .t2En(t2En), .t2Sel(t2Sel), .strb(strb), .maskBits(maskReg),
    .pend(pend), .stat(stat), .setBits(setBits), .winIdx(winIdx),
    .winValid(winValid)
  );

  assign irq = gEn & winValid;
  assign vecOut = winValid ? slotVector(winIdx) : 16'h0000;
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk
  import irq_vector_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input logic clk,
  input logic rstN,
  input logic txEvt,
  input logic t1Ovf,
  input logic ackIn,
  input logic wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wData,
  input logic irq,
  input logic [15:0] vecOut,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] setBits,
  input logic [NSRC-1:0] maskReg,
  input logic [1:0] stat,
  input logic [IDX_W-1:0] winIdx,
  input logic winValid
);
  AST_IRQ_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (vecOut != 16'h0000)); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && winValid && !setBits[winIdx] && !wrEn) |=> !pend[$past(winIdx)]); // R9

  AST_ACK_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && winValid && setBits[winIdx]) |=> pend[$past(winIdx)]); // R9

  AST_TX_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    txEvt |=> (pend[SLOT_TX] && pend[SLOT_SER])); // R3

  AST_T1_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    t1Ovf |=> stat[1]); // R6

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_MASK) |=> (maskReg == $past(wData[NSRC-1:0]))); // R10
endmodule

bind irq_vector_ctrl irq_vector_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .txEvt(txEvt), .t1Ovf(t1Ovf), .ackIn(ackIn),
  .wrEn(wrEn), .addr(addr), .wData(wData), .irq(irq), .vecOut(vecOut),
  .pend(pend), .setBits(setBits), .maskReg(maskReg), .stat(stat),
  .winIdx(winIdx), .winValid(winValid)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEvt = 0, rxEvt = 0, t1Ovf = 0, adDone = 0, dataAvail = 0, outEvt = 0;
  logic swTimer = 0, fifoFour = 0, fifoFull = 0, extPin = 0, capPin = 0;
  logic [15:0] t2Count = 16'h0000;
  logic [1:0] addr = 2'd0;
  logic wrEn = 0, rdEn = 0, ackIn = 0;
  logic [15:0] wData = 16'h0000;
  logic [15:0] rData, vecOut;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [12:0] mPend = '0, mMask = '0;
  logic [15:0] mCtrl = '0;
  logic [1:0] mStat = '0;
  logic mExtS = 0, mExtP = 0, mCapS = 0, mCapP = 0;
  logic [15:0] mT2Prev = '0;

  irq_vector_ctrl dut (
    .clk(clk), .rstN(rstN), .txEvt(txEvt), .rxEvt(rxEvt), .t1Ovf(t1Ovf),
    .adDone(adDone), .dataAvail(dataAvail), .outEvt(outEvt), .swTimer(swTimer),
    .fifoFour(fifoFour), .fifoFull(fifoFull), .extPin(extPin), .capPin(capPin),
    .t2Count(t2Count), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wData(wData),
    .rData(rData), .ackIn(ackIn), .irq(irq), .vecOut(vecOut)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] expVec(input int idx);
    case (idx)
      0: return 16'h2000;  1: return 16'h2002;  2: return 16'h2004;
      3: return 16'h2006;  4: return 16'h2008;  5: return 16'h200A;
      6: return 16'h200C;  7: return 16'h2030;  8: return 16'h2032;
      9: return 16'h2034;  10: return 16'h2036; 11: return 16'h2038;
      12: return 16'h203C;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int winner(input logic [12:0] act);
    int w = -1;
    for (int i = 0; i < 13; i++) if (act[i]) w = i;
    return w;
  endfunction

  function automatic logic [15:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {3'b0, mMask};
      2'd1: return {3'b0, mPend};
      2'd2: return mCtrl;
      default: return {10'b0, mStat[1], mStat[0], 4'b0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [12:0] s, clr;
    logic t2det;
    int w;
    s = '0;
    t2det = (t2Count == (mCtrl[7] ? 16'h8000 : 16'h0000)) && (mT2Prev != t2Count);
    s[0] = (t1Ovf & mCtrl[2]) | (t2det & mCtrl[3]);
    s[1] = adDone; s[2] = dataAvail; s[3] = outEvt;
    s[4] = mExtS & ~mExtP; s[5] = swTimer;
    s[6] = txEvt | rxEvt; s[7] = txEvt; s[8] = rxEvt;
    s[9] = fifoFour; s[10] = mCapS & ~mCapP; s[11] = t2det; s[12] = fifoFull;
    clr = (wrEn && addr == 2'd1) ? wData[12:0] : '0;
    w = winner(mPend & mMask);
    if (ackIn && w >= 0) clr[w] = 1'b1;
    if (rdEn && addr == 2'd3) mStat = '0;
    if (t2det) mStat[0] = 1'b1;
    if (t1Ovf) mStat[1] = 1'b1;
    mPend = (mPend & ~clr) | s;
    if (wrEn && addr == 2'd0) mMask = wData[12:0];
    if (wrEn && addr == 2'd2) mCtrl = wData & 16'h008D;
    mExtP = mExtS; mExtS = extPin;
    mCapP = mCapS; mCapS = capPin;
    mT2Prev = t2Count;
  endtask

  task automatic tick(input string tag);
    int w;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    w = winner(mPend & mMask);
    check({tag, " irq"}, {15'b0, irq}, {15'b0, (mCtrl[0] && w >= 0)});
    check({tag, " vector"}, vecOut, (w >= 0) ? expVec(w) : 16'h0000);
    check({tag, " rData"}, rData, expRead(addr));
    {txEvt, rxEvt, t1Ovf, adDone, dataAvail, outEvt, swTimer, fifoFour, fifoFull} = '0;
    wrEn = 0; rdEn = 0; ackIn = 0;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d, input string tag);
    addr = a; wData = d; wrEn = 1; tick(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state on every register
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      check("R1 reset rData", rData, 16'h0000);
    end
    check("R1 reset irq", {15'b0, irq}, 16'h0000);
    check("R1 reset vector", vecOut, 16'h0000);

    // R10: mask and control write and readback
    busWrite(2'd0, 16'hFFFF, "R10 mask");
    addr = 2'd0; #1; check("R10 mask readback", rData, 16'h1FFF);
    busWrite(2'd2, 16'hFFFF, "R10 ctrl");
    addr = 2'd2; #1; check("R10 ctrl readback", rData, 16'h008D);
    busWrite(2'd2, 16'h0001, "R10 ctrl gen");

    // R2: plain strobes set their own slot
    for (int k = 0; k < 6; k++) begin
      int sl;
      sl = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 5 : (k == 4) ? 9 : 12;
      adDone = (sl == 1); dataAvail = (sl == 2); outEvt = (sl == 3);
      swTimer = (sl == 5); fifoFour = (sl == 9); fifoFull = (sl == 12);
      addr = 2'd1; tick("R2 strobe");
      check("R2 pend bit", rData, 16'(1) << sl);
      check("R8 vector of slot", vecOut, expVec(sl));
      busWrite(2'd1, 16'h1FFF, "R10 w1c");
      check("R10 w1c empty", rData, 16'h0000);
    end

    // R3: serial events set dedicated and shared bits
    txEvt = 1; addr = 2'd1; tick("R3 tx");
    check("R3 tx bits", rData, 16'h00C0);
    rxEvt = 1; tick("R3 rx");
    check("R3 rx bits", rData, 16'h01C0);
    busWrite(2'd1, 16'h1FFF, "R3 clr");

    // R4 R6: timer 1 overflow gated into slot 0, status regardless
    t1Ovf = 1; addr = 2'd1; tick("R4 t1 disabled");
    check("R4 no slot0", rData, 16'h0000);
    addr = 2'd3; #1; check("R6 t1 status", rData, 16'h0020);
    busWrite(2'd2, 16'h0005, "R4 t1 enable");
    t1Ovf = 1; addr = 2'd3; rdEn = 1; tick("R6 read and set");
    check("R6 set wins over read", rData, 16'h0020);
    rdEn = 1; tick("R6 read clear");
    check("R6 cleared", rData, 16'h0000);
    addr = 2'd1; #1; check("R4 slot0 by t1", rData, 16'h0001);
    busWrite(2'd1, 16'h1FFF, "R4 clr");

    // R5: timer 2 overflow at 8000H with slot0 and slot11
    busWrite(2'd2, 16'h0089, "R5 sel 8000");
    t2Count = 16'h7FFF; tick("R5 step");
    t2Count = 16'h8000; addr = 2'd1; tick("R5 hit");
    check("R5 t2 slots", rData, 16'h0801);
    busWrite(2'd1, 16'h1FFF, "R5 clr");
    addr = 2'd1; tick("R5 hold");
    check("R5 no repeat", rData, 16'h0000);
    t2Count = 16'h0000; tick("R5 zero ignored");
    check("R5 zero when sel 8000", rData, 16'h0000);
    addr = 2'd3; #1; check("R6 t2 status", rData, 16'h0010);
    busWrite(2'd2, 16'h0001, "R5 sel 0000");
    t2Count = 16'h0001; tick("R5 step");
    t2Count = 16'h0000; addr = 2'd1; tick("R5 wrap");
    check("R5 slot11 only", rData, 16'h0800);
    busWrite(2'd1, 16'h1FFF, "R5 clr");

    // R7: pin edges, held level gives one event
    extPin = 1; addr = 2'd1; tick("R7 ext edge1");
    check("R7 not yet", rData, 16'h0000);
    tick("R7 ext edge2");
    check("R7 slot4", rData, 16'h0010);
    busWrite(2'd1, 16'h1FFF, "R7 clr");
    tick("R7 held"); tick("R7 held");
    check("R7 one shot", rData, 16'h0000);
    extPin = 0; capPin = 1; tick("R7 cap"); tick("R7 cap");
    check("R7 slot10", rData, 16'h0400);
    capPin = 0;
    busWrite(2'd1, 16'h1FFF, "R7 clr");

    // R8 R9: priority, masking, acknowledge
    dataAvail = 1; fifoFour = 1; tick("R8 two pending");
    check("R8 higher wins", vecOut, 16'h2034);
    busWrite(2'd0, 16'h1DFF, "R8 mask slot9");
    check("R8 masked ignored", vecOut, 16'h2004);
    busWrite(2'd0, 16'h1FFF, "R8 unmask");
    ackIn = 1; tick("R9 ack");
    check("R9 next vector", vecOut, 16'h2004);
    ackIn = 1; dataAvail = 1; tick("R9 ack with event");
    check("R9 event keeps bit", vecOut, 16'h2004);
    busWrite(2'd2, 16'h0000, "R8 global off");
    check("R8 irq off", {15'b0, irq}, 16'h0000);
    busWrite(2'd2, 16'h0001, "R8 global on");
    check("R8 irq on", {15'b0, irq}, 16'h0001);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      txEvt = ($urandom_range(0, 15) == 0); rxEvt = ($urandom_range(0, 15) == 0);
      t1Ovf = ($urandom_range(0, 15) == 0); adDone = ($urandom_range(0, 15) == 0);
      dataAvail = ($urandom_range(0, 15) == 0); outEvt = ($urandom_range(0, 15) == 0);
      swTimer = ($urandom_range(0, 15) == 0); fifoFour = ($urandom_range(0, 15) == 0);
      fifoFull = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) extPin = ~extPin;
      if ($urandom_range(0, 7) == 0) capPin = ~capPin;
      r = $urandom_range(0, 3);
      t2Count = (r == 0) ? 16'h0000 : (r == 1) ? 16'h8000 : 16'($urandom());
      ackIn = ($urandom_range(0, 3) == 0);
      addr = 2'($urandom_range(0, 3));
      rdEn = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 9) == 0) begin
        wrEn = 1;
        wData = 16'($urandom());
      end
      tick("R8 R10 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule